// File: doc/BRIEF.md
# GPIO Edge Interrupt and Wake Unit

This block sits beside a general-purpose I/O port and turns transitions on its input pins into interrupt and wake-up events. Every pin passes through a synchronizer. A transition is found by comparing the synchronized level with its value one clock earlier. Each pin has four enable bits. Two of them, one for rising and one for falling transitions, allow normal interrupts. The other two allow wake-up events in the same way. A pin may enable either direction, both directions or neither.

An enabled normal-interrupt transition sets a sticky pending bit for its pin. One interrupt line goes to the parent controller and stays high while any pending bit is set. Software reads the pending register and services the lowest-numbered bit first. It acknowledges that bit by writing a one to it in the acknowledge register, and repeats until the pending register reads zero. Enabled wake transitions drive a one-cycle wake pulse, and this pulse does not depend on the normal enables. Only edges trigger the block: a pin that is held at a steady level never causes an event.

The register port is a flat single-cycle interface. A write takes effect at the clock edge where `wr_en` is high. Read data follows `addr` combinationally.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset, all four enable registers and the pending register read 0, and both `irq_o` and `wake_o` are 0.
- R2: A 0-to-1 transition on a pin whose rising enable bit (address 0) is set makes that pin's pending bit read 1 exactly three clock edges after the pin changes. This counts two synchronizer stages and the pending register.
- R3: A 1-to-0 transition sets the pending bit only if the pin's falling enable bit (address 1) is set. A pin with both enable bits set is flagged on either transition. A pin with neither bit set is never flagged.
- R4: A write to the acknowledge register (address 5) clears every pending bit written as 1. Bits written as 0 keep their value.
- R5: If a new enabled transition and an acknowledge of the same bit occur at the same clock edge, the bit stays pending.
- R6: `irq_o` is 1 exactly when the pending register (address 4) is nonzero.
- R7: A transition that passes the rising wake enable (address 2) or the falling wake enable (address 3) makes `wake_o` high for exactly one cycle, three edges after the pin change. This works when all normal enables are 0, and wake enables alone never set a pending bit.
- R8: Clearing an enable bit leaves an already pending bit set.
- R9: A pin that is held at a constant level produces no new pending bit after it has been acknowledged, so level triggering does not exist.
- R10: The four enable registers read back what was written. Writes to address 4 have no effect. Address 5 reads as 0, and address 6 returns the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Combined interrupt toward the parent controller |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
The hardest case to reach from the ports is an acknowledge that lands at the same clock edge at which a new transition on the same pin is recognized. The bench first makes pin 0 pending and then toggles the pin. It counts the synchronizer delay and asserts the acknowledge write exactly two cycles after the pin change, so that both events reach the pending register at the same edge. A second acknowledge afterwards shows that the bit stayed set only because of the new transition.

// File: rtl/gei_pkg.sv
package gei_pkg;
    localparam int ADDR_W = 3;

    // Register addresses
    typedef enum logic [ADDR_W-1:0] {
        REG_RISE_EN = 3'd0,
        REG_FALL_EN = 3'd1,
        REG_RISE_WK = 3'd2,
        REG_FALL_WK = 3'd3,
        REG_PEND    = 3'd4,
        REG_ACK     = 3'd5,
        REG_LEVEL   = 3'd6
    } gei_reg_e;
endpackage

// File: rtl/gei_edge_det.sv
module gei_edge_det #(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N-1:0] chain;
        logic [N-1:0]                  prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pins_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[LAST];
    assign rise_o  = st_q.chain[LAST] & ~st_q.prev;
    assign fall_o  = ~st_q.chain[LAST] & st_q.prev;

    // R9: an edge indication never lasts two cycles on the same pin
    a_r9_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
    a_r9_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/gei_cfg_regs.sv
module gei_cfg_regs
    import gei_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wr_data,
    input  logic [N-1:0]      pend_i,
    input  logic [N-1:0]      level_i,
    output logic [N-1:0]      rise_en_o,
    output logic [N-1:0]      fall_en_o,
    output logic [N-1:0]      rise_wk_o,
    output logic [N-1:0]      fall_wk_o,
    output logic [N-1:0]      ack_o,
    output logic [N-1:0]      rd_data
);
    typedef struct packed {
        logic [N-1:0] rise_en;
        logic [N-1:0] fall_en;
        logic [N-1:0] rise_wk;
        logic [N-1:0] fall_wk;
    } cfg_st_t;

    cfg_st_t  cfg_d, cfg_q;
    gei_reg_e sel;

    assign sel = gei_reg_e'(addr);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                REG_RISE_EN: cfg_d.rise_en = wr_data;
                REG_FALL_EN: cfg_d.fall_en = wr_data;
                REG_RISE_WK: cfg_d.rise_wk = wr_data;
                REG_FALL_WK: cfg_d.fall_wk = wr_data;
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        ack_o = '0;
        if (wr_en && sel == REG_ACK) ack_o = wr_data;
    end

    always_comb begin
        case (sel)
            REG_RISE_EN: rd_data = cfg_q.rise_en;
            REG_FALL_EN: rd_data = cfg_q.fall_en;
            REG_RISE_WK: rd_data = cfg_q.rise_wk;
            REG_FALL_WK: rd_data = cfg_q.fall_wk;
            REG_PEND:    rd_data = pend_i;
            REG_LEVEL:   rd_data = level_i;
            default:     rd_data = '0;
        endcase
    end

    assign rise_en_o = cfg_q.rise_en;
    assign fall_en_o = cfg_q.fall_en;
    assign rise_wk_o = cfg_q.rise_wk;
    assign fall_wk_o = cfg_q.fall_wk;

    // R10: an enable register changes only through a write to its own address
    a_r10_rise_en_written: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == REG_RISE_EN) |=> $stable(rise_en_o));
endmodule

// File: rtl/gei_pend.sv
module gei_pend #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    input  logic [N-1:0] rise_wk_i,
    input  logic [N-1:0] fall_wk_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o,
    output logic         irq_o,
    output logic         wake_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic         wake;
    } pend_st_t;

    pend_st_t     st_d, st_q;
    logic [N-1:0] set_vec;
    logic [N-1:0] wk_vec;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign set_vec[i] = (rise_i[i] & rise_en_i[i]) | (fall_i[i] & fall_en_i[i]);
        assign wk_vec[i]  = (rise_i[i] & rise_wk_i[i]) | (fall_i[i] & fall_wk_i[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_i) | set_vec;  // new edge beats ack
        st_d.wake = |wk_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = |st_q.pend;
    assign wake_o = st_q.wake;

    // R4: an acknowledged bit without a new edge is clear next cycle
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(ack_i & ~set_vec)) == '0));
    // R5: an enabled edge always leaves its bit pending, even with an ack
    a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(set_vec)) == $past(set_vec)));
    // R8: a pending bit falls only when acknowledged
    a_r8_sticky_pend: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_o) & ~pend_o) & ~$past(ack_i)) == '0));
    // R2: a pending bit rises only from an enabled edge
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_o & ~$past(pend_o)) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gei_pkg::*;
#(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pins_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wr_data,
    output logic [N-1:0]      rd_data,
    output logic              irq_o,
    output logic              wake_o
);
    logic [N-1:0] level, rise, fall;
    logic [N-1:0] rise_en, fall_en, rise_wk, fall_wk, ack, pend;

    gei_edge_det #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    gei_cfg_regs #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .pend_i(pend), .level_i(level),
        .rise_en_o(rise_en), .fall_en_o(fall_en),
        .rise_wk_o(rise_wk), .fall_wk_o(fall_wk),
        .ack_o(ack), .rd_data(rd_data)
    );

    gei_pend #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .rise_en_i(rise_en), .fall_en_i(fall_en),
        .rise_wk_i(rise_wk), .fall_wk_i(fall_wk),
        .ack_i(ack), .pend_o(pend), .irq_o(irq_o), .wake_o(wake_o)
    );

    // R6: the interrupt line follows the pending register seen by the read port
    a_r6_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 1'b0 && addr == REG_PEND) |-> (irq_o == (rd_data != '0)));
endmodule

// File: tb/gpio_edge_irq_unit_tb.sv
module gpio_edge_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive_pins(logic [31:0] v);
        pins_i = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 reg reset", d, 32'h0);
        end
        check("R1 irq reset", {31'b0, irq_o}, 32'h0);
        check("R1 wake reset", {31'b0, wake_o}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(3'd0, 32'hA5A5_0001); wr(3'd1, 32'h0F0F_0002);
        wr(3'd2, 32'h1234_5678); wr(3'd3, 32'h8000_0003);
        rd(3'd0, d); check("R10 rise enable", d, 32'hA5A5_0001);
        rd(3'd1, d); check("R10 fall enable", d, 32'h0F0F_0002);
        rd(3'd2, d); check("R10 rise wake", d, 32'h1234_5678);
        rd(3'd3, d); check("R10 fall wake", d, 32'h8000_0003);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R10 pending write ignored", d, 32'h0);
        rd(3'd5, d); check("R10 ack reads zero", d, 32'h0);
        for (int a = 0; a < 4; a++) wr(3'(a), 32'h0);
        drive_pins(32'h0000_0300);
        rd(3'd6, d); check("R10 level readback", d, 32'h0000_0300);
        drive_pins(32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(3'd0, 32'h0000_0005);
        pins_i = 32'h0000_0007;
        repeat (2) @(negedge clk);
        rd(3'd4, d); check("R2 not yet pending at two edges", d, 32'h0);
        @(negedge clk);
        rd(3'd4, d); check("R2 rising pending", d, 32'h0000_0005);
        check("R6 irq high", {31'b0, irq_o}, 32'h1);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R4 ack all", d, 32'h0);
        check("R6 irq low", {31'b0, irq_o}, 32'h0);
        drive_pins(32'h0);
        repeat (2) @(negedge clk);
        rd(3'd4, d); check("R3 falling without enable", d, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] d;
        wr(3'd1, 32'h0000_0030); wr(3'd0, 32'h0000_0020);
        drive_pins(32'h0000_0030);
        rd(3'd4, d); check("R3 both rise side", d, 32'h0000_0020);
        wr(3'd5, 32'h0000_0020);
        drive_pins(32'h0);
        rd(3'd4, d); check("R3 falling pending", d, 32'h0000_0030);
        wr(3'd5, 32'h0000_0010);
        rd(3'd4, d); check("R4 zero bits kept", d, 32'h0000_0020);
        wr(3'd5, 32'h0000_0020);
        rd(3'd4, d); check("R4 second ack", d, 32'h0);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    endtask

    task automatic t_conflict();
        logic [31:0] d;
        wr(3'd0, 32'h1); wr(3'd1, 32'h1);
        drive_pins(32'h1);
        rd(3'd4, d); check("R5 setup pending", d, 32'h1);
        pins_i = 32'h0;
        @(negedge clk); @(negedge clk);
        wr(3'd5, 32'h1);  // ack at the edge that sees the falling edge
        rd(3'd4, d); check("R5 edge beats ack", d, 32'h1);
        wr(3'd5, 32'h1);
        rd(3'd4, d); check("R5 later ack clears", d, 32'h0);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    endtask

    task automatic t_mask_clear();
        logic [31:0] d;
        wr(3'd0, 32'h0000_0100);
        drive_pins(32'h0000_0100);
        wr(3'd0, 32'h0);
        rd(3'd4, d); check("R8 pending survives mask clear", d, 32'h0000_0100);
        check("R8 irq still high", {31'b0, irq_o}, 32'h1);
        wr(3'd5, 32'h0000_0100);
        drive_pins(32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(3'd2, 32'h0000_1000);
        pins_i = 32'h0000_1000;
        repeat (2) @(negedge clk);
        check("R7 wake not early", {31'b0, wake_o}, 32'h0);
        @(negedge clk);
        check("R7 wake pulse", {31'b0, wake_o}, 32'h1);
        @(negedge clk);
        check("R7 wake one cycle", {31'b0, wake_o}, 32'h0);
        rd(3'd4, d); check("R7 wake sets no pending", d, 32'h0);
        check("R7 irq stays low", {31'b0, irq_o}, 32'h0);
        pins_i = 32'h0;
        repeat (3) @(negedge clk);
        check("R7 falling wake disabled", {31'b0, wake_o}, 32'h0);
        wr(3'd3, 32'h0000_1000);
        pins_i = 32'h0000_1000;
        repeat (3) @(negedge clk);
        check("R7 rising wake again", {31'b0, wake_o}, 32'h1);
        pins_i = 32'h0;
        repeat (3) @(negedge clk);
        check("R7 falling wake pulse", {31'b0, wake_o}, 32'h1);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(3'd0, 32'h0001_0000);
        drive_pins(32'h0001_0000);
        wr(3'd5, 32'h0001_0000);
        repeat (10) @(negedge clk);
        rd(3'd4, d); check("R9 steady level no retrigger", d, 32'h0);
        wr(3'd0, 32'h0);
        drive_pins(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_rise();
        t_fall_both();
        t_conflict();
        t_mask_clear();
        t_wake();
        t_level();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule